// File: doc/BRIEF.md
# Serial DAC Code Loader

This block receives a DAC code over a three-wire serial link (active-low select, serial clock, serial data) and holds it in a code latch that drives a voltage-output DAC core. The link pins are sampled in the system clock domain. Each select-low period is one frame. In a frame the block shifts in data bits, most significant bit first, on rising serial clock edges. When select is released after a full 16-bit word, the word is moved into the latch and a one-cycle update strobe is raised.

The frame is always 16 bits. At 14- or 12-bit resolution the code sits in the upper bits of the frame, and the trailing bits are ignored. A frame with fewer than 16 clock edges leaves the latch unchanged and raises a one-cycle error pulse. Reset and the asynchronous clear input both force the latch to a start value. In unipolar mode that value is zero. In bipolar mode it is the midscale code of the chosen resolution.

Top module: `dac_serial_loader`

## Requirements
- R1: After reset the code output is 0 when BIPOLAR=0, and 2^(RES_BITS-1) when BIPOLAR=1 (for example 2048 at 12 bits).
- R2: After select has been low for exactly 16 rising serial clock edges, the select rising edge loads the shifted word, MSB first, and update pulses high for exactly one clock.
- R3: While select is high, serial clock and data activity changes neither the code nor the strobes.
- R4: If more than 16 rising edges occur in a frame, only the last 16 bits shifted in are loaded.
- R5: A frame with fewer than 16 rising edges leaves the code unchanged, raises frame_err for one clock and gives no update pulse.
- R6: The code output is RES_BITS wide and equals frame bits [15:16-RES_BITS]. The remaining low frame bits have no effect.
- R7: A low level on clr_n forces the code to the R1 value asynchronously. This includes a pulse shorter than one system clock period. The code stays at that value while clr_n is held low.
- R8: A select rising edge while clr_n is low loads nothing and raises neither update nor frame_err.
- R9: update and frame_err are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| clr_n | input | 1 | Asynchronous active-low clear of the code latch |
| code | output | RES_BITS | Latched DAC code |
| update | output | 1 | One-cycle pulse on each successful load |
| frame_err | output | 1 | One-cycle pulse on a short frame |

## Verification
A table of frames is fed to a 16-bit unipolar instance and to a 12-bit bipolar instance at the same time. The table holds exact 16-edge words, all-ones and LSB-only words, over-long frames of 20 and 24 edges, and short frames of 9 and 0 edges. The exact words check bit order. The LSB-only and trailing-nibble words show that the 12-bit instance ignores the low bits. The long frames show that the leading surplus bits are dropped. The short frames separate a rejected frame from a load. Directed cases then cover clock activity while select is high, a sub-period clear pulse, and a select release during a held clear.

// File: rtl/dac_serial_loader.sv
module dac_serial_loader #(
  parameter int RES_BITS = 16,
  parameter bit BIPOLAR  = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sck,
  input  logic                sdi,
  input  logic                clr_n,
  output logic [RES_BITS-1:0] code,
  output logic                update,
  output logic                frame_err
);
  localparam int FRAME = 16;
  localparam int CW    = $clog2(FRAME + 1);
  localparam logic [RES_BITS-1:0] INIT_CODE =
    BIPOLAR ? (RES_BITS'(1) << (RES_BITS - 1)) : '0;

  logic [2:0]       sck_q, cs_q;
  logic [1:0]       sdi_q, clr_q;
  logic [FRAME-1:0] shreg;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      sdi_q <= '0;
      clr_q <= '1;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q  <= {cs_q[1:0], cs_n};
      sdi_q <= {sdi_q[0], sdi};
      clr_q <= {clr_q[0], clr_n};
    end

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire cs_fall  = ~cs_q[1] & cs_q[2];
  wire cs_rise  = cs_q[1] & ~cs_q[2];
  wire cs_low   = ~cs_q[1];
  wire clr_idle = clr_q[1] & clr_n;
  wire full     = (cnt == CW'(FRAME));
  wire load_ok  = cs_rise & clr_idle & full;
  wire load_bad = cs_rise & clr_idle & ~full;
  wire latch_rst_n = rst_n & clr_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
    end else if (cs_low && sck_rise) begin
      shreg <= {shreg[FRAME-2:0], sdi_q[1]};
      if (!full) cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge latch_rst_n)
    if (!latch_rst_n)  code <= INIT_CODE;
    else if (load_ok)  code <= shreg[FRAME-1 -: RES_BITS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      update    <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      update    <= load_ok;
      frame_err <= load_bad;
    end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(update && frame_err));
  // R2
  update_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> ($past(cnt) == CW'(FRAME) && $past(cs_rise)));
  // R5
  short_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> ($past(cnt) < CW'(FRAME)));
  // R7
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> code == INIT_CODE);
  // R8
  clr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_n && cs_rise) |=> (!update && !frame_err));
  // R4
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FRAME));
endmodule

// File: tb/test_dac_serial_loader.sv
module test_dac_serial_loader;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, sdi = 0, clr_n = 1;
  logic [15:0] code_a;
  logic [11:0] code_b;
  logic upd_a, err_a, upd_b, err_b;
  int checks = 0, errors = 0;
  int nupd_a = 0, nerr_a = 0, nupd_b = 0, nerr_b = 0;
  logic [15:0] exp16;
  bit done = 0;

  always #10 clk = ~clk;

  dac_serial_loader #(.RES_BITS(16), .BIPOLAR(1'b0)) i_dac_serial_loader (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .clr_n(clr_n),
    .code(code_a), .update(upd_a), .frame_err(err_a));

  dac_serial_loader #(.RES_BITS(12), .BIPOLAR(1'b1)) i_dac_serial_loader_b12 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi), .clr_n(clr_n),
    .code(code_b), .update(upd_b), .frame_err(err_b));

  always @(negedge clk) begin
    if (upd_a) nupd_a++;
    if (err_a) nerr_a++;
    if (upd_b) nupd_b++;
    if (err_b) nerr_b++;
  end

  // {edge count, bit pattern}; bits pattern[n-1:0] are sent MSB first
  localparam logic [36:0] VEC [8] = '{
    {5'd16, 32'h0000_A5C3},
    {5'd16, 32'h0000_FFFF},
    {5'd16, 32'h0000_0001},
    {5'd20, 32'h000B_1234},
    {5'd9,  32'h0000_01FF},
    {5'd0,  32'h0000_0000},
    {5'd16, 32'h0000_800F},
    {5'd24, 32'h00FF_0000}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int n, input logic [31:0] pat);
    cs_n = 0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = pat[i];
      wait_clk(4);
      sck = 1;
      wait_clk(4);
      sck = 0;
    end
    wait_clk(4);
    cs_n = 1;
    wait_clk(8);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1;
    wait_clk(2);
    check("R1 unipolar reset", code_a, 0);
    check("R1 bipolar 12-bit reset", code_b, 12'h800);
    check("R9 no strobes at reset", {upd_a, err_a}, 0);
    exp16 = 16'h0000;

    for (int v = 0; v < 8; v++) begin
      int n, pu, pe;
      n  = VEC[v][36:32];
      pu = nupd_a; pe = nerr_a;
      send_frame(n, VEC[v][31:0]);
      if (n >= 16) begin
        exp16 = VEC[v][15:0];
        check("R2/R4 update count", nupd_a - pu, 1);
        check("R5 no err on good frame", nerr_a - pe, 0);
        check("R2/R4 16-bit code", code_a, exp16);
        check("R6 12-bit code", code_b, exp16[15:4]);
      end else begin
        check("R5 err count", nerr_a - pe, 1);
        check("R5 no update on short frame", nupd_a - pu, 0);
        check("R5 16-bit code kept", code_a, exp16);
        check("R5 12-bit code kept", code_b, (v == 0) ? 12'h800 : exp16[15:4]);
      end
    end
    check("R9 pulse totals match", nupd_a + nerr_a, 8);
    check("R9 pulse totals b12", nupd_b + nerr_b, 8);

    // R3: clocking with select high
    begin
      int pu, pe;
      pu = nupd_a; pe = nerr_a;
      for (int i = 0; i < 20; i++) begin
        sdi = i[0];
        wait_clk(3);
        sck = 1;
        wait_clk(3);
        sck = 0;
      end
      wait_clk(8);
      check("R3 code unchanged", code_a, exp16);
      check("R3 no strobes", (nupd_a - pu) + (nerr_a - pe), 0);
    end

    // R7: short clear pulse between clock edges
    send_frame(16, 32'hBEEF);
    check("R2 preload", code_a, 16'hBEEF);
    @(posedge clk);
    #3 clr_n = 0;
    #5 clr_n = 1;
    wait_clk(2);
    check("R7 short clear 16-bit", code_a, 0);
    check("R7 short clear 12-bit midscale", code_b, 12'h800);

    // R8: select release during held clear
    begin
      int pu, pe;
      send_frame(16, 32'h1357);
      check("R2 preload 2", code_a, 16'h1357);
      pu = nupd_a; pe = nerr_a;
      cs_n = 0;
      wait_clk(4);
      for (int i = 15; i >= 0; i--) begin
        sdi = ~i[0];
        wait_clk(4);
        sck = 1;
        wait_clk(4);
        sck = 0;
      end
      wait_clk(4);
      clr_n = 0;
      cs_n = 1;
      wait_clk(12);
      check("R7 held clear 16-bit", code_a, 0);
      check("R7 held clear 12-bit", code_b, 12'h800);
      check("R8 no strobes under clear", (nupd_a - pu) + (nerr_a - pe), 0);
      clr_n = 1;
      wait_clk(6);
      check("R8 stays cleared after release", code_a, 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule